// File: doc/BRIEF.md
# USB Host Frame-Boundary Update Unit

This unit does the housekeeping of a USB host controller at the end of each frame. Host and driver share a communications area in memory. When the frame-boundary strobe is seen, the unit does five things in one cycle:

- it selects the periodic-list head for the frame that ends;
- it reloads the frame-remaining toggle;
- it advances the 16-bit frame number;
- it decides whether the done queue is written back;
- it sets the matching interrupt status bits.

It then writes two 32-bit words into the shared area and reports completion: first the new frame number, then the done-head word.

Retired transfers load the done-head register through a push input. Each push carries a delay code, and the delay counter takes the smaller of the code and its current value. A writeback happens only when that counter has run down to zero and the driver has acknowledged the previous writeback by clearing its status bit. Two events put the unit into a halted state for good: a failed memory write, or a null shared-area base. Only reset clears it.

Top module: `usbh_frame_update`

## Requirements
- R1: After reset the following hold: frame number 0, all status bits 0, done-head 0, no memory request, not halted, delay counter 7.
- R2: At a boundary with periodic processing enabled, `list_head` takes table entry `frame_number[4:0]` (entry i at bits i*32+31..i*32), using the number from before the increment, and `list_valid` is 1. With periodic processing off, `list_valid` is 0.
- R3: Each boundary does three things to the frame number and status. The frame number goes up by one, modulo 2^16. Status bit 2 is set. Status bit 5 is set when bit 15 of the frame number changes.
- R4: Each boundary copies `fi_toggle` into `fr_toggle`.
- R5: A writeback happens only when the delay counter is 0 and status bit 1 is clear. It does four things:
  - the done-head value becomes the word to be written;
  - `done_head` is cleared;
  - the counter is loaded with 7;
  - status bit 1 is set.

  At any other boundary the word written is the one from the last writeback (0 after reset).
- R6: Bit 0 of a written-back word is set when any of status bits 30..0 is both set and enabled in `int_enable`. Status is taken as it stood before that boundary.
- R7: A boundary that does no writeback decrements the delay counter only when its value is between 1 and 6. A push loads `done_head` with `done_value` and sets the counter to the smaller of the counter and `done_delay`.
- R8: After each boundary the unit issues two write beats, each held until `mem_ack`. The first goes to base+0x80 with data {16'h0, frame number}. The second goes to base+0x84 with the done-head word. `fb_done` pulses for one cycle after the second acknowledge.
- R9: A failure halts the unit. A failure is either `mem_err` with an acknowledge, or a boundary seen while `hcca_base` is 0. On a failure:
  - status bit 4 is set;
  - `bus_halted` rises and stays high;
  - any remaining beats are dropped;
  - `fb_done` pulses.

  A boundary with a null base leaves the frame number unchanged. Once halted, the unit ignores strobes.
- R10: `irq` is 1 exactly when `int_enable[31]` is set and some status bit is both set and enabled. Writing 1s on `status_clear` clears the matching status bits.
- R11: A strobe that arrives while a write is in progress has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| frame_tick | input | 1 | Frame-boundary strobe |
| periodic_en | input | 1 | Periodic list processing enabled |
| int_table | input | 1024 | 32 interrupt-list head words |
| fi_toggle | input | 1 | Frame-interval toggle bit |
| int_enable | input | 32 | Interrupt enables, bit 31 master |
| status_clear | input | 32 | Write-1-to-clear status pulse |
| done_push | input | 1 | Retired transfer pushes done head |
| done_value | input | 32 | New done-head value |
| done_delay | input | 3 | Delay code of the retired transfer |
| hcca_base | input | 32 | Shared area base address |
| mem_req | output | 1 | Write beat request |
| mem_addr | output | 32 | Write beat address |
| mem_wdata | output | 32 | Write beat data |
| mem_ack | input | 1 | Beat accepted |
| mem_err | input | 1 | Beat failed (valid with ack) |
| frame_number | output | 16 | Current frame number |
| list_head | output | 32 | Selected periodic-list head |
| list_valid | output | 1 | list_head belongs to last boundary |
| fr_toggle | output | 1 | Frame-remaining toggle |
| int_status | output | 32 | Interrupt status |
| irq | output | 1 | Interrupt request |
| done_head | output | 32 | Done-head register |
| bus_halted | output | 1 | Unit stopped after fatal error |
| fb_done | output | 1 | Frame-boundary work finished |

## Verification
Random frames vary five things: the periodic enable, the enable masks, the pushes with mixed delay codes, the clearing of the writeback status, and the acknowledge latency. These show apart three cases: a writeback from a held-off one, the bit-0 pending flag from a plain copy, and table indexing from a stale head. A long burst with the strobe held high and immediate acknowledges drives the frame number up to the bit-15 crossing. The same burst shows that strobes during a write are dropped. Directed cases are a failed second beat and a null base, which differ in whether the frame number had already advanced.

// File: rtl/usbh_frame_update.sv
module usbh_frame_update (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_tick,
  input  logic          periodic_en,
  input  logic [1023:0] int_table,
  input  logic          fi_toggle,
  input  logic [31:0]   int_enable,
  input  logic [31:0]   status_clear,
  input  logic          done_push,
  input  logic [31:0]   done_value,
  input  logic [2:0]    done_delay,
  input  logic [31:0]   hcca_base,
  output logic          mem_req,
  output logic [31:0]   mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic          mem_ack,
  input  logic          mem_err,
  output logic [15:0]   frame_number,
  output logic [31:0]   list_head,
  output logic          list_valid,
  output logic          fr_toggle,
  output logic [31:0]   int_status,
  output logic          irq,
  output logic [31:0]   done_head,
  output logic          bus_halted,
  output logic          fb_done
);
  localparam logic [31:0] FN_OFS = 32'h80;
  localparam logic [31:0] DH_OFS = 32'h84;
  localparam logic [2:0]  DLY_MAX = 3'd7;

  typedef enum logic [1:0] {S_IDLE, S_BEAT0, S_BEAT1} state_t;
  state_t state;

  logic [2:0]  delay_cnt, cnt_n;
  logic [31:0] wb_word, st_n, dh_n;
  logic [15:0] fn_next;
  logic        start, go, wb_due, any_pend, fail;

  assign start    = frame_tick && (state == S_IDLE) && !bus_halted;
  assign go       = start && (hcca_base != 32'h0);
  assign wb_due   = (delay_cnt == 3'd0) && !int_status[1];
  assign any_pend = |(int_enable[30:0] & int_status[30:0]);
  assign fn_next  = frame_number + 16'd1;
  assign fail     = (start && hcca_base == 32'h0) || (state != S_IDLE && mem_ack && mem_err);

  assign mem_req   = state != S_IDLE;
  assign mem_addr  = hcca_base + ((state == S_BEAT1) ? DH_OFS : FN_OFS);
  assign mem_wdata = (state == S_BEAT1) ? wb_word : {16'h0, frame_number};
  assign irq       = int_enable[31] && any_pend;

  always_comb begin
    st_n  = int_status & ~status_clear;
    cnt_n = delay_cnt;
    dh_n  = done_head;
    if (go) begin
      st_n[2] = 1'b1;
      if (fn_next[15] != frame_number[15]) st_n[5] = 1'b1;
      if (wb_due) begin
        st_n[1] = 1'b1;
        dh_n    = 32'h0;
        cnt_n   = DLY_MAX;
      end else if (delay_cnt != 3'd0 && delay_cnt != DLY_MAX) begin
        cnt_n = delay_cnt - 3'd1;
      end
    end
    if (fail) st_n[4] = 1'b1;
    if (done_push) begin
      dh_n = done_value;
      if (done_delay < cnt_n) cnt_n = done_delay;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= S_IDLE;
      frame_number <= 16'h0;
      list_head    <= 32'h0;
      list_valid   <= 1'b0;
      fr_toggle    <= 1'b0;
      int_status   <= 32'h0;
      done_head    <= 32'h0;
      delay_cnt    <= DLY_MAX;
      wb_word      <= 32'h0;
      bus_halted   <= 1'b0;
      fb_done      <= 1'b0;
    end else begin
      int_status <= st_n;
      delay_cnt  <= cnt_n;
      done_head  <= dh_n;
      fb_done    <= 1'b0;
      if (start && !go) begin
        bus_halted <= 1'b1;
        fb_done    <= 1'b1;
      end
      if (go) begin
        list_valid   <= periodic_en;
        if (periodic_en) list_head <= int_table[frame_number[4:0]*32 +: 32];
        fr_toggle    <= fi_toggle;
        frame_number <= fn_next;
        if (wb_due) wb_word <= done_head | {31'h0, any_pend};
        state        <= S_BEAT0;
      end
      if (state != S_IDLE && mem_ack) begin
        if (mem_err) begin
          bus_halted <= 1'b1;
          fb_done    <= 1'b1;
          state      <= S_IDLE;
        end else if (state == S_BEAT0) begin
          state <= S_BEAT1;
        end else begin
          state   <= S_IDLE;
          fb_done <= 1'b1;
        end
      end
    end
  end

  AST_FN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> frame_number == $past(frame_number) + 16'd1); // R3
  AST_TOGGLE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> fr_toggle == $past(fi_toggle)); // R4
  AST_WB_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (go && wb_due && !done_push) |=> (done_head == 32'h0 && int_status[1])); // R5
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_wdata))); // R8
  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    bus_halted |-> !mem_req); // R9
  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    bus_halted |=> bus_halted); // R9
endmodule

// File: tb/usbh_frame_update_bench.sv
module usbh_frame_update_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic frame_tick = 0, periodic_en = 0, fi_toggle = 0, done_push = 0;
  logic [1023:0] tbl;
  logic [31:0] en = 0, status_clear = 0, done_value = 0, hcca_base = 32'h0001_0000;
  logic [2:0] done_delay = 0;
  logic mem_ack = 0, mem_err = 0;
  logic mem_req, list_valid, fr_toggle, irq, bus_halted, fb_done;
  logic [31:0] mem_addr, mem_wdata, list_head, int_status, done_head;
  logic [15:0] frame_number;

  int n_chk = 0, n_bad = 0;
  logic [15:0] m_fn;
  logic [2:0]  m_cnt;
  logic [31:0] m_dh, m_shadow, m_st, m_head;
  logic        m_valid, m_tog;

  always #(CLK_PERIOD/2) clk = ~clk;

  usbh_frame_update u_usbh_frame_update (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .periodic_en(periodic_en),
    .int_table(tbl), .fi_toggle(fi_toggle), .int_enable(en), .status_clear(status_clear),
    .done_push(done_push), .done_value(done_value), .done_delay(done_delay),
    .hcca_base(hcca_base), .mem_req(mem_req), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_err(mem_err), .frame_number(frame_number), .list_head(list_head),
    .list_valid(list_valid), .fr_toggle(fr_toggle), .int_status(int_status), .irq(irq),
    .done_head(done_head), .bus_halted(bus_halted), .fb_done(fb_done));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic exp_irq();
    return en[31] && (|(en[30:0] & m_st[30:0]));
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    m_fn = 0; m_cnt = 7; m_dh = 0; m_shadow = 0; m_st = 0;
    m_head = 0; m_valid = 0; m_tog = 0;
    @(negedge clk);
  endtask

  task automatic push(input logic [31:0] v, input logic [2:0] d);
    done_push = 1; done_value = v; done_delay = d;
    @(negedge clk);
    done_push = 0;
    m_dh = v;
    if (d < m_cnt) m_cnt = d;
    check("R7 push loads done head", done_head, v);
  endtask

  task automatic clear_status(input logic [31:0] m);
    status_clear = m;
    @(negedge clk);
    status_clear = 0;
    m_st = m_st & ~m;
    check("R10 status clear", int_status, m_st);
  endtask

  task automatic run_frame(input bit pe, input int err_at, input bit busy_tick);
    logic flag;
    logic [15:0] nf;
    bit failed;
    failed = 0;
    periodic_en = pe;
    flag = |(en[30:0] & m_st[30:0]);
    m_valid = pe;
    if (pe) m_head = tbl[m_fn[4:0]*32 +: 32];
    m_tog = fi_toggle;
    if (m_cnt == 0 && !m_st[1]) begin
      m_shadow = m_dh | {31'h0, flag};
      m_dh = 0; m_cnt = 7; m_st[1] = 1'b1;
    end else if (m_cnt != 0 && m_cnt != 7) m_cnt = m_cnt - 3'd1;
    nf = m_fn + 16'd1;
    if (nf[15] != m_fn[15]) m_st[5] = 1'b1;
    m_st[2] = 1'b1;
    m_fn = nf;
    @(negedge clk); frame_tick = 1;
    @(negedge clk); frame_tick = 0;
    check("R3 frame number step", {16'h0, frame_number}, {16'h0, m_fn});
    check("R2 list valid", {31'h0, list_valid}, {31'h0, m_valid});
    if (m_valid) check("R2 list head entry", list_head, m_head);
    check("R4 toggle reload", {31'h0, fr_toggle}, {31'h0, m_tog});
    for (int b = 0; b < 2; b++) begin
      check("R8 request raised", {31'h0, mem_req}, 32'h1);
      check("R8 beat address", mem_addr, hcca_base + (b == 0 ? 32'h80 : 32'h84));
      check(b == 0 ? "R8 frame number beat" : "R5 R6 done head beat",
            mem_wdata, b == 0 ? {16'h0, m_fn} : m_shadow);
      for (int w = 0; w < int'($urandom_range(0, 2)); w++) begin
        if (busy_tick && b == 0 && w == 0) frame_tick = 1;
        @(negedge clk);
        frame_tick = 0;
        check("R8 request held", {31'h0, mem_req}, 32'h1);
      end
      mem_ack = 1; mem_err = (err_at == b + 1);
      @(negedge clk);
      mem_ack = 0; mem_err = 0;
      if (err_at == b + 1) begin failed = 1; break; end
    end
    if (failed) m_st[4] = 1'b1;
    check("R8 R9 done pulse", {31'h0, fb_done}, 32'h1);
    check("R8 request dropped", {31'h0, mem_req}, 32'h0);
    check("R9 halted flag", {31'h0, bus_halted}, {31'h0, failed});
    check("R3 R5 status", int_status, m_st);
    check("R5 done head reg", done_head, m_dh);
    check("R11 frame number after", {16'h0, frame_number}, {16'h0, m_fn});
    check("R10 irq", {31'h0, irq}, {31'h0, exp_irq()});
  endtask

  task automatic drain();
    mem_ack = 1;
    for (int i = 0; i < 10 && !fb_done; i++) @(negedge clk);
    mem_ack = 0;
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 32; i++) tbl[i*32 +: 32] = $urandom;
    do_reset();
    check("R1 frame number", {16'h0, frame_number}, 32'h0);
    check("R1 status", int_status, 32'h0);
    check("R1 done head", done_head, 32'h0);
    check("R1 no request", {31'h0, mem_req}, 32'h0);
    check("R1 not halted", {31'h0, bus_halted}, 32'h0);

    run_frame(1'b1, 0, 1'b0);
    push(32'hA000_0010, 3'd2);
    run_frame(1'b0, 0, 1'b0);
    run_frame(1'b1, 0, 1'b0);
    en = 32'h8000_0004;
    run_frame(1'b1, 0, 1'b0);
    check("R6 pending flag in bit 0", m_shadow, 32'hA000_0011);
    clear_status(32'h0000_0026);
    push(32'h0000_0200, 3'd0);
    run_frame(1'b1, 0, 1'b1);

    for (int it = 0; it < 80; it++) begin
      fi_toggle = $urandom_range(0, 1);
      en = {$urandom_range(0, 1) == 1, 24'h0, 7'($urandom)};
      if ($urandom_range(0, 2) == 0) push($urandom, 3'($urandom_range(0, 7)));
      if ($urandom_range(0, 2) == 0) clear_status({$urandom} & 32'h0000_0026);
      run_frame($urandom_range(0, 1) == 1, 0, $urandom_range(0, 3) == 0);
    end

    frame_tick = 1; mem_ack = 1;
    for (int i = 0; i < 120000 && frame_number != 16'h7FFE; i++) @(negedge clk);
    frame_tick = 0;
    repeat (3) @(negedge clk);
    mem_ack = 0;
    check("R11 idle after burst", {31'h0, mem_req}, 32'h0);
    clear_status(32'hFFFF_FFFF);
    @(negedge clk); frame_tick = 1; @(negedge clk); frame_tick = 0;
    check("R3 step to 7FFF", {16'h0, frame_number}, 32'h7FFF);
    check("R3 no overflow below bit 15", {31'h0, int_status[5]}, 32'h0);
    drain();
    status_clear = 32'hFFFF_FFFF; @(negedge clk); status_clear = 0;
    @(negedge clk); frame_tick = 1; @(negedge clk); frame_tick = 0;
    check("R3 step to 8000", {16'h0, frame_number}, 32'h8000);
    check("R3 bit 15 toggle status", {31'h0, int_status[5]}, 32'h1);
    drain();

    do_reset();
    en = 0;
    run_frame(1'b1, 2, 1'b0);
    @(negedge clk); frame_tick = 1; @(negedge clk); frame_tick = 0;
    check("R9 strobe ignored when halted", {16'h0, frame_number}, {16'h0, m_fn});
    check("R9 no request when halted", {31'h0, mem_req}, 32'h0);

    do_reset();
    hcca_base = 32'h0;
    @(negedge clk); frame_tick = 1; @(negedge clk); frame_tick = 0;
    check("R9 null base halts", {31'h0, bus_halted}, 32'h1);
    check("R9 null base error bit", int_status, 32'h10);
    check("R9 null base done pulse", {31'h0, fb_done}, 32'h1);
    check("R9 null base keeps frame", {16'h0, frame_number}, 32'h0);
    check("R9 null base no request", {31'h0, mem_req}, 32'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule